// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM Core

This block is a synthesizable behavioural model of a pipelined synchronous burst static RAM. Each word is 36 bits wide and made of four 9-bit byte lanes. Every control input, the address and the write data are sampled on the rising clock edge. A burst is opened by one of two address strobes. One strobe is meant for a processor and the other for a cache controller. The two strobes qualify the chip enables in different ways. After a burst is opened, an internal two-bit counter steps through the four words of the aligned group, either in linear order or in interleaved order.

Read data pass through an output register, so the data for a read sampled at one edge reach the output after the next edge. An asynchronous output enable then gates them onto the port. The tristate data bus is split into a write-data input and a read-data output, with a valid flag that stands for "bus driven". Writes happen on the edge at which they are sampled. Byte-lane selects allow partial-word writes, and a global write forces all four lanes.

The full 32K-word part uses `ADDR_W = 15`. The default is smaller, which keeps elaboration light.

Top module: `psb_sram_core`

## Requirements
- R1: A cycle is a write when `allw_n` is low, in which case all four lanes are written. It is also a write when `we_n` is low and at least one bit of `lane_n` is low; then only the lanes whose `lane_n` bit is low are written. Lane i covers `wdata[9*i+8:9*i]`. Any other cycle of an active burst is a read.
- R2: The chip enables are active when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. In that case, `pstb_n` low loads `addr` as the burst start, resets the burst counter and performs a read, whatever the write controls are.
- R3: `cstb_n` low with `pstb_n` high starts a burst at `addr` when the enables are active, and it reads or writes per R1. With the enables inactive, the same condition deselects the device.
- R4: `pstb_n` low while `ce1_n` is high is ignored. With `cstb_n` high, the cycle is a continue or suspend cycle as in R5, and with `cstb_n` low it deselects. `pstb_n` low with `ce1_n` low but `ce2` low or `ce3_n` high deselects.
- R5: With both strobes high and the device active, `adv_n` low steps the burst counter and uses the new address, and `adv_n` high keeps the current address. Either cycle reads or writes per R1. After reset or a deselect, such cycles do nothing until a new burst start.
- R6: Burst order only changes the low two address bits; the upper bits stay those of the start address. With `ilv`=0, step k uses (start+k) mod 4. With `ilv`=1, step k uses start XOR k.
- R7: A read sampled at edge N shows its data on `rdata`, with `rvalid` high, from edge N+1 on, provided `oe_n` is low.
- R8: A write updates the array at the edge where it is sampled. A read of that address in the next cycle returns the new data.
- R9: `oe_n` acts without the clock. While it is high, `rvalid` is low and `rdata` is zero. While it is low, the registered read data appear at once.
- R10: After a deselect, write or idle cycle at edge N, `rvalid` is low from edge N+1 on. Reset clears the pipeline, the burst state and the active state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | External word address |
| wdata | input | 36 | Write data, four 9-bit lanes |
| ce1_n | input | 1 | Chip enable, active low; also gates the processor strobe |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| pstb_n | input | 1 | Processor-side burst start strobe, active low |
| cstb_n | input | 1 | Controller-side burst start strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| lane_n | input | 4 | Per-lane write selects, active low |
| allw_n | input | 1 | Global write of all lanes, active low |
| we_n | input | 1 | Write enable qualifying `lane_n`, active low |
| ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| rdata | output | 36 | Read data, zero when not valid |
| rvalid | output | 1 | Read data driven (bus not high-impedance) |

## Verification
A wrong burst counter or a wrong base register shows up as read data taken from the wrong word of the aligned group. This is visible on `rdata` two edges after the faulty cycle. Wrong decoding of the strobes and enables shows as a missing or unexpected `rvalid` after the following edge, or as a write that lands where it should not. That write becomes visible only when the word is read back later, so the bench fills a small address window and reads it back often. A fault in the lane masks shows as a 9-bit slice that differs from the reference on the next read of that word.

// File: rtl/psb_pkg.sv
package psb_pkg;

    localparam int LANES  = 4;
    localparam int LANE_W = 9;
    localparam int WORD_W = LANES * LANE_W;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_DESEL,
        OP_LOAD_RD,
        OP_LOAD_RW,
        OP_NEXT,
        OP_HOLD
    } op_e;

    typedef struct packed {
        op_e              op;
        logic             wr;
        logic [LANES-1:0] lanes;
    } cmd_t;

    function automatic logic enables_ok(input logic c1_n, input logic c2, input logic c3_n);
        return !c1_n && c2 && !c3_n;
    endfunction

    function automatic logic op_accesses(input op_e op);
        return (op == OP_LOAD_RD) || (op == OP_LOAD_RW) || (op == OP_NEXT) || (op == OP_HOLD);
    endfunction

endpackage

// File: rtl/psb_cmd_decode.sv
module psb_cmd_decode
    import psb_pkg::*;
(
    input  logic             ce1_n,
    input  logic             ce2,
    input  logic             ce3_n,
    input  logic             pstb_n,
    input  logic             cstb_n,
    input  logic             adv_n,
    input  logic [LANES-1:0] lane_n,
    input  logic             allw_n,
    input  logic             we_n,
    input  logic             active,
    output cmd_t             cmd
);

    logic             en_ok;
    logic             wr_req;
    logic [LANES-1:0] wr_lanes;

    always_comb begin
        en_ok = enables_ok(ce1_n, ce2, ce3_n);
        if (!allw_n) begin
            wr_lanes = '1;
        end else if (!we_n) begin
            wr_lanes = ~lane_n;
        end else begin
            wr_lanes = '0;
        end
        wr_req = |wr_lanes;
    end

    always_comb begin
        cmd = '{op: OP_IDLE, wr: 1'b0, lanes: '0};
        if (!pstb_n && en_ok) begin
            cmd.op = OP_LOAD_RD;
        end else if (!cstb_n) begin
            cmd.op = en_ok ? OP_LOAD_RW : OP_DESEL;
        end else if (!pstb_n && !ce1_n) begin
            cmd.op = OP_DESEL;
        end else if (active) begin
            cmd.op = adv_n ? OP_HOLD : OP_NEXT;
        end
        if (cmd.op == OP_LOAD_RW || cmd.op == OP_NEXT || cmd.op == OP_HOLD) begin
            cmd.wr    = wr_req;
            cmd.lanes = wr_lanes;
        end
    end

    // R2
    pstart_read_chk: assert final (!(cmd.op == OP_LOAD_RD && cmd.wr));

    // R1
    lanes_need_write_chk: assert final (cmd.wr == (|cmd.lanes));

endmodule

// File: rtl/psb_burst_ctr.sv
module psb_burst_ctr #(
    parameter int ADDR_W  = 11,
    parameter int BURST_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  psb_pkg::op_e      op,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              ilv,
    output logic [ADDR_W-1:0] cur_addr
);
    import psb_pkg::*;

    localparam int HI_W = ADDR_W - BURST_W;

    logic [ADDR_W-1:0]  base_q;
    logic [BURST_W-1:0] cnt_q;
    logic [BURST_W-1:0] cnt_use;
    logic [BURST_W-1:0] low_bits;

    always_comb begin
        cnt_use = (op == OP_NEXT) ? cnt_q + 1'b1 : cnt_q;
        low_bits = ilv ? (base_q[BURST_W-1:0] ^ cnt_use)
                       : (base_q[BURST_W-1:0] + cnt_use);
        if (op == OP_LOAD_RD || op == OP_LOAD_RW) begin
            cur_addr = ext_addr;
        end else begin
            cur_addr = {base_q[ADDR_W-1:BURST_W], low_bits};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else if (op == OP_LOAD_RD || op == OP_LOAD_RW) begin
            base_q <= ext_addr;
            cnt_q  <= '0;
        end else if (op == OP_NEXT) begin
            cnt_q <= cnt_use;
        end
    end

    // R2
    load_clears_cnt_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_LOAD_RD || op == OP_LOAD_RW) |=> (cnt_q == '0 && base_q == $past(ext_addr)));

    // R5
    next_steps_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_NEXT) |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R6
    upper_fixed_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_NEXT || op == OP_HOLD) |-> (cur_addr[ADDR_W-1:BURST_W] == base_q[ADDR_W-1:BURST_W]));

    // R5
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_HOLD || op == OP_IDLE || op == OP_DESEL) |=> ($stable(cnt_q) && $stable(base_q)));

    if (HI_W < 1) begin : g_bad_width
        initial $error("ADDR_W must exceed BURST_W");
    end

endmodule

// File: rtl/psb_lane_array.sv
module psb_lane_array #(
    parameter int ADDR_W = 11
) (
    input  logic                                  clk,
    input  logic                                  wen,
    input  logic [psb_pkg::LANES-1:0]             wlanes,
    input  logic [ADDR_W-1:0]                     waddr,
    input  logic [psb_pkg::WORD_W-1:0]            wdata,
    input  logic [ADDR_W-1:0]                     raddr,
    output logic [psb_pkg::WORD_W-1:0]            rdata
);
    import psb_pkg::*;

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] store [DEPTH];

        always_ff @(posedge clk) begin
            if (wen && wlanes[g]) begin
                store[waddr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        assign rdata[g*LANE_W +: LANE_W] = store[raddr];
    end

endmodule

// File: rtl/psb_sram_core.sv
module psb_sram_core
    import psb_pkg::*;
#(
    parameter int ADDR_W  = 11,
    parameter int BURST_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [35:0]       wdata,
    input  logic              ce1_n,
    input  logic              ce2,
    input  logic              ce3_n,
    input  logic              pstb_n,
    input  logic              cstb_n,
    input  logic              adv_n,
    input  logic [3:0]        lane_n,
    input  logic              allw_n,
    input  logic              we_n,
    input  logic              ilv,
    input  logic              oe_n,
    output logic [35:0]       rdata,
    output logic              rvalid
);

    cmd_t              cmd;
    logic              active_q;
    logic [ADDR_W-1:0] cur_addr;
    logic              do_read;
    logic              do_write;
    logic              acc_rd_q;
    logic [ADDR_W-1:0] acc_addr_q;
    logic [WORD_W-1:0] arr_rdata;
    logic [WORD_W-1:0] out_q;
    logic              out_vld_q;

    psb_cmd_decode u_dec (
        .ce1_n  (ce1_n),
        .ce2    (ce2),
        .ce3_n  (ce3_n),
        .pstb_n (pstb_n),
        .cstb_n (cstb_n),
        .adv_n  (adv_n),
        .lane_n (lane_n),
        .allw_n (allw_n),
        .we_n   (we_n),
        .active (active_q),
        .cmd    (cmd)
    );

    psb_burst_ctr #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .op       (cmd.op),
        .ext_addr (addr),
        .ilv      (ilv),
        .cur_addr (cur_addr)
    );

    assign do_read  = !rst && op_accesses(cmd.op) && !cmd.wr;
    assign do_write = !rst && op_accesses(cmd.op) && cmd.wr;

    psb_lane_array #(.ADDR_W(ADDR_W)) u_arr (
        .clk    (clk),
        .wen    (do_write),
        .wlanes (cmd.lanes),
        .waddr  (cur_addr),
        .wdata  (wdata),
        .raddr  (acc_addr_q),
        .rdata  (arr_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q   <= 1'b0;
            acc_rd_q   <= 1'b0;
            acc_addr_q <= '0;
            out_vld_q  <= 1'b0;
            out_q      <= '0;
        end else begin
            if (cmd.op == OP_LOAD_RD || cmd.op == OP_LOAD_RW) begin
                active_q <= 1'b1;
            end else if (cmd.op == OP_DESEL) begin
                active_q <= 1'b0;
            end
            acc_rd_q   <= do_read;
            acc_addr_q <= cur_addr;
            out_vld_q  <= acc_rd_q;
            if (acc_rd_q) begin
                out_q <= arr_rdata;
            end
        end
    end

    assign rvalid = out_vld_q && !oe_n;
    assign rdata  = rvalid ? out_q : '0;

    // R10
    desel_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd.op == OP_DESEL) |=> !acc_rd_q);

    // R10
    write_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        do_write |=> !acc_rd_q);

    // R7
    vld_follows_access_chk: assert property (@(posedge clk) disable iff (rst)
        !acc_rd_q |=> !out_vld_q);

    // R5
    desel_inactive_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd.op == OP_DESEL) |=> !active_q);

    // R9
    oe_gate_chk: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> (!rvalid && rdata == '0));

endmodule

// File: tb/tb_psb_sram_core.sv
`timescale 1ns/1ps
module tb_psb_sram_core;

    localparam int AW = 11;

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] addr;
    logic [35:0]   wdata;
    logic          ce1_n, ce2, ce3_n, pstb_n, cstb_n, adv_n;
    logic [3:0]    lane_n;
    logic          allw_n, we_n, ilv, oe_n;
    logic [35:0]   rdata;
    logic          rvalid;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    psb_sram_core #(.ADDR_W(AW)) dut (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata),
        .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
        .pstb_n(pstb_n), .cstb_n(cstb_n), .adv_n(adv_n),
        .lane_n(lane_n), .allw_n(allw_n), .we_n(we_n),
        .ilv(ilv), .oe_n(oe_n), .rdata(rdata), .rvalid(rvalid)
    );

    // ---------------- reference model ----------------
    logic [35:0] rmem [int];
    bit          m_active;
    int          m_base, m_cnt;
    bit          m_rd;
    int          m_addr;
    bit          o_vld;
    bit          o_known;
    logic [35:0] o_dat;

    always @(posedge clk) begin
        bit en, wr, rd, ld;
        int kind, off, a;
        logic [3:0] ln;
        if (rst) begin
            m_active = 0; m_base = 0; m_cnt = 0; m_rd = 0; o_vld = 0; o_known = 0;
        end else begin
            o_vld = m_rd;
            if (m_rd) begin
                o_known = rmem.exists(m_addr);
                if (o_known) o_dat = rmem[m_addr];
            end
            en = !ce1_n && ce2 && !ce3_n;
            ln = !allw_n ? 4'hF : (!we_n ? ~lane_n : 4'h0);
            // kind: 0 none, 1 deselect, 2 forced read start, 3 start, 4 step, 5 stay
            if (!pstb_n && en)              kind = 2;
            else if (!cstb_n)               kind = en ? 3 : 1;
            else if (!pstb_n && !ce1_n)     kind = 1;
            else if (m_active)              kind = adv_n ? 5 : 4;
            else                            kind = 0;
            ld = (kind == 2 || kind == 3);
            if (ld) begin
                m_base = int'(addr); m_cnt = 0; m_active = 1;
            end
            if (kind == 1) m_active = 0;
            if (kind == 4) m_cnt = (m_cnt + 1) % 4;
            off = ilv ? ((m_base % 4) ^ m_cnt) : (((m_base % 4) + m_cnt) % 4);
            a   = ld ? int'(addr) : (m_base - (m_base % 4) + off);
            wr  = (kind >= 3) && (ln != 4'h0);
            rd  = (kind >= 2) && !wr;
            if (wr) begin
                logic [35:0] w;
                w = rmem.exists(a) ? rmem[a] : 36'h0;
                for (int i = 0; i < 4; i++)
                    if (ln[i]) w[i*9 +: 9] = wdata[i*9 +: 9];
                rmem[a] = w;
            end
            m_rd = rd;
            m_addr = a;
        end
    end

    task automatic check_out(input string tag);
        bit          ev;
        logic [35:0] ed;
        ev = o_vld && !oe_n;
        ed = ev ? o_dat : 36'h0;
        total++;
        if (rvalid !== ev || (ev && o_known && rdata !== ed) || (!ev && rdata !== 36'h0)) begin
            bad++;
            $display("FAIL %s: rvalid=%0b rdata=%h expected rvalid=%0b rdata=%h",
                     tag, rvalid, rdata, ev, ed);
        end
    endtask

    task automatic cyc(input string tag);
        @(posedge clk);
        @(negedge clk);
        check_out(tag);
    endtask

    task automatic idle_in();
        ce1_n = 0; ce2 = 1; ce3_n = 0;
        pstb_n = 1; cstb_n = 1; adv_n = 1;
        lane_n = 4'hF; allw_n = 1; we_n = 1;
    endtask

    task automatic c_start(input int a, input bit w, input logic [35:0] d, input string tag);
        idle_in(); cstb_n = 0; addr = AW'(a); wdata = d;
        if (w) allw_n = 0;
        cyc(tag);
    endtask

    // ---------------- stimulus ----------------
    initial begin
        rst = 1; addr = '0; wdata = '0; ilv = 0; oe_n = 0;
        idle_in();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset clears output
        check_out("R10");
        rst = 0;

        // fill words 0..63 with controller writes (R3, R1)
        for (int i = 0; i < 64; i++) c_start(i, 1, {4{9'(i * 7 + 3)}}, "R3");
        idle_in(); cstb_n = 0; ce2 = 0; cyc("R3");  // deselect
        idle_in(); cyc("R10"); cyc("R10");

        // R2: processor start with writes requested is still a read
        idle_in(); pstb_n = 0; addr = 5; allw_n = 0; wdata = 36'h123456789; cyc("R2");
        idle_in(); cyc("R7"); cyc("R7");

        // R6 linear burst from 6
        ilv = 0;
        idle_in(); pstb_n = 0; addr = 6; cyc("R6");
        for (int k = 0; k < 4; k++) begin idle_in(); adv_n = 0; cyc("R6"); end
        idle_in(); cyc("R5"); cyc("R5");

        // R6 interleaved burst from 9
        ilv = 1;
        idle_in(); pstb_n = 0; addr = 9; cyc("R6");
        for (int k = 0; k < 4; k++) begin idle_in(); adv_n = 0; cyc("R6"); end
        ilv = 0;

        // R8: write after processor start with hold reuses the address
        idle_in(); pstb_n = 0; addr = 20; cyc("R8");
        idle_in(); we_n = 0; lane_n = 4'b1010; wdata = 36'hABCDEF012; cyc("R1");
        idle_in(); cyc("R8"); cyc("R8"); cyc("R8");

        // R4: processor strobe ignored while ce1_n high
        idle_in(); ce1_n = 1; pstb_n = 0; addr = 40; adv_n = 0; cyc("R4"); cyc("R4");
        idle_in(); ce1_n = 1; pstb_n = 0; cstb_n = 0; cyc("R4");
        idle_in(); cyc("R4"); cyc("R4");
        idle_in(); pstb_n = 0; addr = 3; cyc("R4");
        idle_in(); pstb_n = 0; ce3_n = 1; cyc("R4"); cyc("R10"); cyc("R10");

        // R9: output enable gating
        idle_in(); pstb_n = 0; addr = 12; cyc("R9");
        idle_in(); cyc("R9");
        oe_n = 1; #1; check_out("R9");
        oe_n = 0; #1; check_out("R9");
        cyc("R9");

        // random mixed traffic
        for (int n = 0; n < 3000; n++) begin
            int r;
            idle_in();
            r = $urandom_range(0, 99);
            addr = AW'($urandom_range(0, 63));
            wdata = {$urandom(), 4'($urandom())};
            ilv = (r < 3) ? ~ilv : ilv;
            if (r < 12)      pstb_n = 0;
            else if (r < 24) cstb_n = 0;
            else if (r < 28) begin pstb_n = 0; ce1_n = 1; end
            adv_n = $urandom_range(0, 1);
            ce2   = ($urandom_range(0, 9) != 0);
            ce3_n = ($urandom_range(0, 9) == 0);
            if ($urandom_range(0, 3) == 0) allw_n = 0;
            if ($urandom_range(0, 2) == 0) begin we_n = 0; lane_n = 4'($urandom()); end
            oe_n = ($urandom_range(0, 7) == 0);
            cyc("R5");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        total++; bad++;
        $display("FAIL watchdog: R7 run did not end, actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule